// File: doc/BRIEF.md
# Transmit Ring Interrupt Cause Generator

This block turns the progress of a transmit descriptor ring into interrupt causes. It watches the ring's head and tail pointers and the completion events from the descriptor engine. It keeps three sticky cause bits: ring drained, descriptor done and low-water crossing. It drives one interrupt line through a mask. Software reads the causes through a small read-to-clear port.

A completion that asks for a status report raises the descriptor-done cause at once. If the completion also asks for a delayed interrupt, the cause is postponed by two countdown timers, and the cause that results is the same descriptor-done bit. The packet timer starts again from its full value on every new delayed completion, so it measures how long no new work has arrived. The absolute timer is armed once, by the first delayed completion, and bounds the total wait. The low-water cause compares the number of available descriptors with a threshold. That count is the tail-to-head distance, wrapped modulo the ring length. The cause fires once, on the crossing into the threshold.

Top module: `tx_ring_irq_cause`

## Requirements
- R1: Cause bit 0 (ring drained) is set on the clock edge after which head_ptr equals tail_ptr, having differed at the previous edge. Remaining equal sets it no further.
- R2: A completion (done_vld) with done_rs=1 and done_ide=0 sets cause bit 1 (descriptor done) at that edge. A completion with done_rs=0 sets nothing and starts no timer.
- R3: A completion with done_rs=1 and done_ide=1 (non-zero delays) does not set bit 1 at once. Bit 1 is set pkt_delay cycles after the most recent such completion, because each one reloads the packet timer.
- R4: The absolute timer is armed only by a delayed completion that finds it idle. It sets bit 1 abs_delay cycles after that completion, whatever later completions occur.
- R5: When either timer expires, both timers return to idle, and no further delayed cause follows without a new delayed completion. If pkt_delay or abs_delay is zero, a delayed completion sets bit 1 at once.
- R6: Available descriptors are (tail_ptr - head_ptr) modulo ring_len. Cause bit 2 (low water) is set when that count goes from above low_mark to at most low_mark. Staying at or below it does not set the bit again.
- R7: Cause bits stay set until read. A cycle with rd_en=1 returns the bits on rd_data (bit 0 drained, bit 1 done, bit 2 low water) and clears them at that edge. A cause raised at the same edge is kept.
- R8: irq is high exactly when some cause bit is set whose bit in irq_mask (same positions) is 1.
- R9: After reset all cause bits are clear, irq is low and both timers are idle. A ring that is already drained or below the threshold raises no cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| head_ptr | input | PTR_W | Ring head pointer (next descriptor to process) |
| tail_ptr | input | PTR_W | Ring tail pointer (one past last posted descriptor) |
| ring_len | input | PTR_W+1 | Number of descriptors in the ring |
| low_mark | input | PTR_W | Low-water threshold on available descriptors |
| done_vld | input | 1 | A descriptor completion occurs this cycle |
| done_rs | input | 1 | Completion requests a status report |
| done_ide | input | 1 | Completion requests a delayed interrupt |
| pkt_delay | input | TMR_W | Packet (restarting) delay, in cycles |
| abs_delay | input | TMR_W | Absolute delay, in cycles |
| irq_mask | input | 3 | Per-cause enable for the interrupt line |
| rd_en | input | 1 | Read and clear the cause register this cycle |
| rd_data | output | 3 | Current cause bits |
| irq | output | 1 | Interrupt line |

## Verification
The bench places delayed completions so that the absolute timer has to expire while the packet timer is still being reloaded. A design that reloaded the absolute timer would never fire there. A design that left the packet timer running after the expiry would raise a second cause later. The bench also moves the pointers across the wrap point of the ring. An unwrapped distance would miss the low-water crossing or report it at the wrong place. It lowers the count further after a crossing, to catch a level-triggered cause that re-arms. A completion is issued in the same cycle as a read, and a design that lost that cause in the clear would show an empty second read.

// File: rtl/tx_ring_irq_cause.sv
module tx_ring_irq_cause #(
  parameter int PTR_W = 8,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] head_ptr,
  input  logic [PTR_W-1:0] tail_ptr,
  input  logic [PTR_W:0]   ring_len,
  input  logic [PTR_W-1:0] low_mark,
  input  logic             done_vld,
  input  logic             done_rs,
  input  logic             done_ide,
  input  logic [TMR_W-1:0] pkt_delay,
  input  logic [TMR_W-1:0] abs_delay,
  input  logic [2:0]       irq_mask,
  input  logic             rd_en,
  output logic [2:0]       rd_data,
  output logic             irq
);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [TMR_W-1:0] TMR_ONE = TMR_W'(1);

  logic [CNT_W-1:0] avail_raw, avail;
  logic             ring_eq, low_now, eq_q, low_q;
  logic             report, dly_req, now_done;
  logic [TMR_W-1:0] pkt_cnt, abs_cnt;
  logic             pkt_fire, abs_fire, tmr_fire;
  logic [2:0]       cause, set_vec;

  assign avail_raw = {1'b0, tail_ptr} - {1'b0, head_ptr};
  assign avail     = (tail_ptr >= head_ptr) ? avail_raw : avail_raw + ring_len;
  assign ring_eq   = (head_ptr == tail_ptr);
  assign low_now   = (avail <= {1'b0, low_mark});

  assign report   = done_vld & done_rs;
  assign dly_req  = report & done_ide & (pkt_delay != '0) & (abs_delay != '0);
  assign now_done = report & ~dly_req;

  assign pkt_fire = (pkt_cnt == TMR_ONE);
  assign abs_fire = (abs_cnt == TMR_ONE);
  assign tmr_fire = pkt_fire | abs_fire;

  assign set_vec = {low_now & ~low_q, now_done | tmr_fire, ring_eq & ~eq_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q  <= 1'b1;
      low_q <= 1'b1;
    end else begin
      eq_q  <= ring_eq;
      low_q <= low_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pkt_cnt <= '0;
    else if (dly_req)        pkt_cnt <= pkt_delay;
    else if (tmr_fire)       pkt_cnt <= '0;
    else if (pkt_cnt != '0)  pkt_cnt <= pkt_cnt - TMR_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     abs_cnt <= '0;
    else if (dly_req && (abs_cnt == '0 || tmr_fire)) abs_cnt <= abs_delay;
    else if (tmr_fire)                              abs_cnt <= '0;
    else if (abs_cnt != '0)                         abs_cnt <= abs_cnt - TMR_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause <= '0;
    else        cause <= (rd_en ? 3'b000 : cause) | set_vec;
  end

  assign rd_data = cause;
  assign irq     = |(cause & irq_mask);
endmodule

// File: rtl/tx_ring_irq_cause_chk.sv
module tx_ring_irq_cause_chk #(
  parameter int PTR_W = 8,
  parameter int TMR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PTR_W-1:0] head_ptr,
  input logic [PTR_W-1:0] tail_ptr,
  input logic             done_vld,
  input logic             done_rs,
  input logic             done_ide,
  input logic [2:0]       irq_mask,
  input logic             rd_en,
  input logic [2:0]       rd_data,
  input logic             irq,
  input logic [TMR_W-1:0] pkt_cnt,
  input logic [TMR_W-1:0] abs_cnt
);
  a_r1_drain_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (head_ptr != tail_ptr) ##1 (head_ptr == tail_ptr) |=> rd_data[0]);

  a_r2_report_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && done_rs && !done_ide) |=> rd_data[1]);

  a_r3_timer_expiry_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_cnt == 1 || abs_cnt == 1) |=> rd_data[1]);

  a_r5_both_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((pkt_cnt == 1 || abs_cnt == 1) && !(done_vld && done_rs && done_ide))
    |=> (pkt_cnt == 0 && abs_cnt == 0));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ((rd_data & $past(rd_data)) == $past(rd_data)));

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 3'b000) |-> !irq);
endmodule

bind tx_ring_irq_cause tx_ring_irq_cause_chk #(.PTR_W(PTR_W), .TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .head_ptr(head_ptr), .tail_ptr(tail_ptr),
  .done_vld(done_vld), .done_rs(done_rs), .done_ide(done_ide),
  .irq_mask(irq_mask), .rd_en(rd_en), .rd_data(rd_data), .irq(irq),
  .pkt_cnt(pkt_cnt), .abs_cnt(abs_cnt)
);

// File: tb/test_tx_ring_irq_cause.sv
module test_tx_ring_irq_cause;
  localparam int PTR_W = 8;
  localparam int TMR_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [PTR_W-1:0] head_ptr = '0, tail_ptr = '0, low_mark = 8'd2;
  logic [PTR_W:0]   ring_len = 9'd16;
  logic             done_vld = 1'b0, done_rs = 1'b0, done_ide = 1'b0;
  logic [TMR_W-1:0] pkt_delay = 16'd10, abs_delay = 16'd100;
  logic [2:0]       irq_mask = 3'b000;
  logic             rd_en = 1'b0;
  logic [2:0]       rd_data;
  logic             irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tx_ring_irq_cause #(.PTR_W(PTR_W), .TMR_W(TMR_W)) i_tx_ring_irq_cause (
    .clk(clk), .rst_n(rst_n), .head_ptr(head_ptr), .tail_ptr(tail_ptr),
    .ring_len(ring_len), .low_mark(low_mark), .done_vld(done_vld),
    .done_rs(done_rs), .done_ide(done_ide), .pkt_delay(pkt_delay),
    .abs_delay(abs_delay), .irq_mask(irq_mask), .rd_en(rd_en),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic rs, input logic ide);
    done_vld = 1'b1; done_rs = rs; done_ide = ide;
    @(negedge clk);
    done_vld = 1'b0; done_rs = 1'b0; done_ide = 1'b0;
  endtask

  task automatic read_causes(output logic [2:0] v);
    rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R9 causes after reset", rd_data, 0);
    check("R9 irq after reset", irq, 0);
  endtask

  task automatic t_drain;
    logic [2:0] v;
    tail_ptr = 8'd5; tick(1);
    head_ptr = 8'd5; tick(1);
    read_causes(v);
    check("R1 drained bit", v[0], 1);
    check("R6 low bit on drain", v[2], 1);
    read_causes(v);
    check("R7 cleared by read", v, 0);
    tick(3);
    check("R1 no re-set while equal", rd_data, 0);
  endtask

  task automatic t_low_water;
    logic [2:0] v;
    tail_ptr = 8'd10; tick(1);
    head_ptr = 8'd8;  tick(1);
    read_causes(v);
    check("R6 crossing to 2", v, 3'b100);
    head_ptr = 8'd9; tick(1);
    read_causes(v);
    check("R6 no re-fire below mark", v, 0);
    tail_ptr = 8'd3; tick(1);
    read_causes(v);
    check("R6 wrapped count 10 above mark", v, 0);
    head_ptr = 8'd1; tick(1);
    read_causes(v);
    check("R6 wrapped crossing", v, 3'b100);
    head_ptr = 8'd3; tick(1);
    read_causes(v);
    check("R1 drain without low re-fire", v, 3'b001);
  endtask

  task automatic t_report;
    logic [2:0] v;
    pulse(1'b1, 1'b0);
    read_causes(v);
    check("R2 immediate done", v, 3'b010);
    pulse(1'b0, 1'b1);
    tick(12);
    read_causes(v);
    check("R2 no report no cause", v, 0);
  endtask

  task automatic t_pkt_timer;
    logic [2:0] v;
    pkt_delay = 16'd10; abs_delay = 16'd100;
    pulse(1'b1, 1'b1);
    check("R3 not immediate", rd_data[1], 0);
    tick(9);
    check("R3 before expiry", rd_data[1], 0);
    tick(1);
    check("R3 at expiry", rd_data[1], 1);
    read_causes(v);
    pulse(1'b1, 1'b1);
    tick(5);
    pulse(1'b1, 1'b1);
    tick(9);
    check("R3 reload holds off", rd_data[1], 0);
    tick(1);
    check("R3 reloaded expiry", rd_data[1], 1);
    read_causes(v);
    tick(100);
    read_causes(v);
    check("R5 no stale absolute fire", v, 0);
  endtask

  task automatic t_abs_timer;
    logic [2:0] v;
    pkt_delay = 16'd10; abs_delay = 16'd25;
    pulse(1'b1, 1'b1);
    for (int k = 0; k < 4; k++) begin
      tick(5);
      pulse(1'b1, 1'b1);
    end
    check("R4 before absolute expiry", rd_data[1], 0);
    tick(1);
    check("R4 absolute expiry", rd_data[1], 1);
    read_causes(v);
    tick(15);
    check("R5 timers idle after expiry", rd_data, 0);
  endtask

  task automatic t_zero_delay;
    logic [2:0] v;
    pkt_delay = 16'd0; abs_delay = 16'd25;
    pulse(1'b1, 1'b1);
    read_causes(v);
    check("R5 zero delay immediate", v, 3'b010);
    pkt_delay = 16'd10;
  endtask

  task automatic t_read_race;
    logic [2:0] v;
    rd_en = 1'b1; done_vld = 1'b1; done_rs = 1'b1; done_ide = 1'b0;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0; done_vld = 1'b0; done_rs = 1'b0;
    check("R7 read before set", v, 0);
    read_causes(v);
    check("R7 set during read kept", v, 3'b010);
  endtask

  task automatic t_mask;
    logic [2:0] v;
    pulse(1'b1, 1'b0);
    irq_mask = 3'b010; #1;
    check("R8 enabled cause", irq, 1);
    irq_mask = 3'b000; #1;
    check("R8 all masked", irq, 0);
    irq_mask = 3'b101; #1;
    check("R8 other bits only", irq, 0);
    irq_mask = 3'b111;
    read_causes(v);
    #1 check("R8 cleared cause drops irq", irq, 0);
    irq_mask = 3'b000;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_drain();
    t_low_water();
    t_report();
    t_pkt_timer();
    t_abs_timer();
    t_zero_delay();
    t_read_race();
    t_mask();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule